// File: doc/BRIEF.md
# Guarded Event Counter Read Port

This block holds a small bank of wide event counters. Each counter advances by one in every cycle in which its own event line is high. Unprivileged code can read any counter through a single read port, so it does not need to call into supervisor software for every sample. Each read request carries a full 32-bit counter number, the caller's privilege level (0 is the most trusted), an environment select, a user-read enable flag and a secure-mode status bit. The block answers one cycle later. The answer is either the counter value, split into a 32-bit low word and a high word, or a general-protection fault with a zero error code.

The counters sit in a data slot space at a fixed offset. Counter number k lives in data slot k+4, and slots 0 to 3 hold no counter. A configuration port lets privileged software do two things. It can load a counter's value, and it can set or clear a counter's privileged-monitor bit. In the native environment, that bit keeps the counter hidden from nonzero privilege levels. Decode of the read instruction, ordering against other instructions, and delivery of the fault all happen outside this block.

Top module: `pmc_read_unit`

## Requirements
- R1: A synchronous reset clears every counter to zero, clears every privileged-monitor bit, and holds rsp_valid low.
- R2: A counter increases by exactly one on every clock edge at which its event input is high, and holds its value otherwise.
- R3: The request's counter number is compared in all 32 bits. Any value of 4 or more faults, even when its low bits would name a counter (for example 0x0001_0002).
- R4: With req_native low (legacy environment), a read of a valid counter is granted when req_ctl_en is 1 or req_cpl is 0, and faults otherwise.
- R5: With req_native high, a read of a valid counter is granted at req_cpl 0. At a nonzero level it is granted only if the counter's privileged-monitor bit is 0 and the secured condition (req_secure is 1, or req_ctl_en is 0) is false. Otherwise it faults.
- R6: Counter number k is read from data slot k+4, and each number returns the value of its own counter.
- R7: A granted read returns counter bits 31:0 on rsp_lo and counter bits 47:32 on rsp_hi.
- R8: rsp_valid is high exactly one cycle after each cycle with req_valid high. A fault shows as rsp_fault = 1 with rsp_hi, rsp_lo and rsp_err all zero. rsp_err is zero on every response.
- R9: The value returned is the counter's value in the request cycle. It does not include an event counted at the same edge.
- R10: A configuration write with cfg_is_priv = 0 loads cfg_wdata into the counter chosen by cfg_sel, and the load wins over an event in the same cycle. A write with cfg_is_priv = 1 sets that counter's privileged-monitor bit to cfg_wdata bit 0.
- R11: A counter holding all ones wraps to zero on its next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_in | input | NCTR | One event line per counter |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Counter chosen for the configuration write |
| cfg_is_priv | input | 1 | 1: write the privileged-monitor bit; 0: load the counter |
| cfg_wdata | input | CNT_W | Load value, or the new privileged-monitor bit in bit 0 |
| req_valid | input | 1 | Single-cycle read request |
| req_idx | input | 32 | Counter number, compared in all 32 bits |
| req_cpl | input | 2 | Privilege level of the caller |
| req_native | input | 1 | 1: native environment rule; 0: legacy rule |
| req_ctl_en | input | 1 | User-read enable control flag |
| req_secure | input | 1 | Secure-mode status bit |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_fault | output | 1 | General-protection fault |
| rsp_err | output | 16 | Fault error code, always zero |
| rsp_hi | output | CNT_W-32 | Upper counter bits |
| rsp_lo | output | 32 | Low 32 counter bits |

## Verification
Each response is due at the first clock edge after its request cycle. The bench drives a request on a falling edge, computes the expected value from its own counter model as it stood before the coming rising edge, and then samples the outputs on the following falling edge. The model updates the counters and monitor bits at the rising edge: a load takes priority over an event. A configuration or event in one cycle can therefore be seen by a read made in the next cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   localparam int unsigned IDX_W = 32;
   localparam int unsigned LO_W  = 32;
   localparam int unsigned ERR_W = 16;

   typedef struct packed {
      logic       native;
      logic       ctl_en;
      logic       secure;
      logic [1:0] cpl;
   } pmc_mode_t;

   // Permission rule for one read, given the selected counter's monitor bit
   function automatic logic pmc_allow(input pmc_mode_t m, input logic priv_bit);
      logic secured;
      logic kernel;
      secured = m.secure | ~m.ctl_en;
      kernel  = (m.cpl == 2'd0);
      if (m.native) begin
         return kernel | (~priv_bit & ~secured);
      end
      return m.ctl_en | kernel;
   endfunction

endpackage

// File: rtl/pmc_event_ctr.sv
module pmc_event_ctr #(
   parameter int unsigned W = 48
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         evt,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] cnt
);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (ld) begin
         cnt <= ld_val;
      end else if (evt) begin
         cnt <= cnt + W'(1);
      end
   end

endmodule

// File: rtl/pmc_access_check.sv
module pmc_access_check
   import pmc_pkg::*;
#(
   parameter int unsigned NCTR      = 4,
   parameter int unsigned SLOT_BASE = 4,
   parameter int unsigned SLOT_W    = 3
) (
   input  logic [IDX_W-1:0]  idx,
   input  pmc_mode_t         mode,
   input  logic [NCTR-1:0]   priv_bits,
   output logic              idx_ok,
   output logic              grant,
   output logic [SLOT_W-1:0] slot
);

   logic priv_sel;

   // Whole-word compare: high bits must be zero for a hit
   assign idx_ok = (idx < IDX_W'(NCTR));

   always_comb begin
      priv_sel = 1'b0;
      for (int i = 0; i < int'(NCTR); i++) begin
         if (idx == IDX_W'(i)) priv_sel = priv_bits[i];
      end
   end

   assign slot  = SLOT_W'(idx) + SLOT_W'(SLOT_BASE);
   assign grant = idx_ok & pmc_allow(mode, priv_sel);

endmodule

// File: rtl/pmc_read_unit.sv
module pmc_read_unit
   import pmc_pkg::*;
#(
   parameter int unsigned NCTR      = 4,
   parameter int unsigned CNT_W     = 48,
   parameter int unsigned SLOT_BASE = 4,
   localparam int unsigned SEL_W    = (NCTR > 1) ? $clog2(NCTR) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NCTR-1:0]  evt_in,
   input  logic             cfg_we,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic             cfg_is_priv,
   input  logic [CNT_W-1:0] cfg_wdata,
   input  logic             req_valid,
   input  logic [31:0]      req_idx,
   input  logic [1:0]       req_cpl,
   input  logic             req_native,
   input  logic             req_ctl_en,
   input  logic             req_secure,
   output logic             rsp_valid,
   output logic             rsp_fault,
   output logic [15:0]      rsp_err,
   output logic [CNT_W-33:0] rsp_hi,
   output logic [31:0]      rsp_lo
);

   localparam int unsigned NSLOT  = SLOT_BASE + NCTR;
   localparam int unsigned SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
   localparam int unsigned HI_W   = CNT_W - LO_W;

   // Elaboration-time parameter checks
   if (CNT_W <= LO_W || CNT_W > 64) begin : g_bad_width
      $error("CNT_W must be in 33..64");
   end
   if (NCTR < 1) begin : g_bad_count
      $error("NCTR must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q  [NCTR];
   logic [CNT_W-1:0] slot_d [NSLOT];
   logic [NCTR-1:0]  priv_q;

   // Counter bank
   for (genvar g = 0; g < int'(NCTR); g++) begin : g_ctr
      logic ld;
      assign ld = cfg_we & ~cfg_is_priv & (cfg_sel == SEL_W'(g));
      pmc_event_ctr #(.W(CNT_W)) i_ctr (
         .clk    (clk),
         .rst    (rst),
         .evt    (evt_in[g]),
         .ld     (ld),
         .ld_val (cfg_wdata),
         .cnt    (cnt_q[g])
      );
   end

   // Privileged-monitor bits
   always_ff @(posedge clk) begin
      if (rst) begin
         priv_q <= '0;
      end else if (cfg_we && cfg_is_priv) begin
         for (int i = 0; i < int'(NCTR); i++) begin
            if (cfg_sel == SEL_W'(i)) priv_q[i] <= cfg_wdata[0];
         end
      end
   end

   // Data slot space: counters sit above SLOT_BASE, lower slots read zero
   for (genvar s = 0; s < int'(NSLOT); s++) begin : g_slot
      if (s < int'(SLOT_BASE)) begin : g_empty
         assign slot_d[s] = '0;
      end else begin : g_ctr_slot
         assign slot_d[s] = cnt_q[s - int'(SLOT_BASE)];
      end
   end

   // Request check
   pmc_mode_t         mode;
   logic              idx_ok;
   logic              grant;
   logic [SLOT_W-1:0] slot;
   logic [CNT_W-1:0]  rd_val;

   assign mode = '{native: req_native, ctl_en: req_ctl_en,
                   secure: req_secure, cpl: req_cpl};

   pmc_access_check #(
      .NCTR      (NCTR),
      .SLOT_BASE (SLOT_BASE),
      .SLOT_W    (SLOT_W)
   ) i_acc (
      .idx       (req_idx),
      .mode      (mode),
      .priv_bits (priv_q),
      .idx_ok    (idx_ok),
      .grant     (grant),
      .slot      (slot)
   );

   assign rd_val = grant ? slot_d[slot] : '0;

   // Response register: snapshot of the counter in the request cycle
   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_hi    <= '0;
         rsp_lo    <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_fault <= req_valid & ~grant;
         if (req_valid) begin
            rsp_lo <= rd_val[LO_W-1:0];
            rsp_hi <= rd_val[CNT_W-1:LO_W];
         end else begin
            rsp_lo <= '0;
            rsp_hi <= '0;
         end
      end
   end

   assign rsp_err = '0;

   logic unused_ok;
   assign unused_ok = idx_ok ^ (HI_W == 0);

endmodule

// File: rtl/pmc_read_unit_chk.sv
module pmc_read_unit_chk #(
   parameter int unsigned NCTR  = 4,
   parameter int unsigned CNT_W = 48,
   parameter int unsigned SEL_W = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             req_valid,
   input logic [31:0]      req_idx,
   input logic [1:0]       req_cpl,
   input logic             req_native,
   input logic             req_ctl_en,
   input logic             req_secure,
   input logic             rsp_valid,
   input logic             rsp_fault,
   input logic [15:0]      rsp_err,
   input logic [CNT_W-33:0] rsp_hi,
   input logic [31:0]      rsp_lo
);

   p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !rsp_valid);

   p_rsp_follows_req_r8: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> rsp_valid);

   p_no_spurious_rsp_r8: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !rsp_valid);

   p_fault_zero_data_r8: assert property (@(posedge clk) disable iff (rst)
      rsp_fault |-> (rsp_valid && rsp_hi == '0 && rsp_lo == '0));

   p_err_zero_r8: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> (rsp_err == '0));

   p_bad_index_r3: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_idx >= 32'(NCTR)) |=> rsp_fault);

   p_legacy_rule_r4: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_native && req_idx < 32'(NCTR))
      |=> (rsp_fault == $past(!(req_ctl_en || req_cpl == 2'd0))));

   p_native_kernel_r5: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_native && req_idx < 32'(NCTR) && req_cpl == 2'd0)
      |=> !rsp_fault);

   p_native_secured_r5: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_native && req_cpl != 2'd0 && (req_secure || !req_ctl_en))
      |=> rsp_fault);

endmodule

bind pmc_read_unit pmc_read_unit_chk #(.NCTR(NCTR), .CNT_W(CNT_W), .SEL_W(SEL_W)) i_chk (.*);

// File: tb/test_pmc_read_unit.sv
module test_pmc_read_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  evt_in = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic        cfg_is_priv = 1'b0;
   logic [47:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_idx = '0;
   logic [1:0]  req_cpl = '0;
   logic        req_native = 1'b0;
   logic        req_ctl_en = 1'b0;
   logic        req_secure = 1'b0;
   logic        rsp_valid;
   logic        rsp_fault;
   logic [15:0] rsp_err;
   logic [15:0] rsp_hi;
   logic [31:0] rsp_lo;

   int checks = 0;
   int fails  = 0;

   logic [47:0] mdl [4];
   logic [3:0]  mpriv;

   always #5 clk = ~clk;

   pmc_read_unit i_pmc_read_unit (
      .clk(clk), .rst(rst), .evt_in(evt_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_is_priv(cfg_is_priv), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
      .req_idx(req_idx), .req_cpl(req_cpl), .req_native(req_native),
      .req_ctl_en(req_ctl_en), .req_secure(req_secure), .rsp_valid(rsp_valid),
      .rsp_fault(rsp_fault), .rsp_err(rsp_err), .rsp_hi(rsp_hi), .rsp_lo(rsp_lo)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit allow_exp(input logic [31:0] idx, input logic [1:0] cpl,
                                    input bit nat, input bit ce, input bit sec);
      bit secured;
      if (idx >= 32'd4) return 1'b0;
      secured = sec || !ce;
      if (nat) return (cpl == 2'd0) || (!mpriv[idx[1:0]] && !secured);
      return ce || (cpl == 2'd0);
   endfunction

   // One cycle: drive at a falling edge, model at the rising edge, sample next falling edge
   task automatic tick(input logic [3:0] ev, input bit rq = 0, input logic [31:0] idx = 0,
                       input logic [1:0] cpl = 0, input bit nat = 0, input bit ce = 0,
                       input bit sec = 0, input bit cw = 0, input logic [1:0] cs = 0,
                       input bit cp = 0, input logic [47:0] cd = 0, input string tag = "R2");
      bit          exp_f;
      logic [47:0] exp_v;
      string       ftag;
      exp_f = !allow_exp(idx, cpl, nat, ce, sec);
      exp_v = exp_f ? 48'd0 : mdl[idx[1:0]];
      ftag  = (idx >= 32'd4) ? "R3" : (nat ? "R5" : "R4");
      evt_in = ev; req_valid = rq; req_idx = idx; req_cpl = cpl; req_native = nat;
      req_ctl_en = ce; req_secure = sec; cfg_we = cw; cfg_sel = cs;
      cfg_is_priv = cp; cfg_wdata = cd;
      @(posedge clk);
      for (int k = 0; k < 4; k++) begin
         if (cw && !cp && cs == 2'(k)) mdl[k] = cd;
         else if (ev[k]) mdl[k] = mdl[k] + 48'd1;
      end
      if (cw && cp) mpriv[cs] = cd[0];
      @(negedge clk);
      check(rsp_valid == rq, "R8", 64'(rsp_valid), 64'(rq));
      if (rq) begin
         check(rsp_fault == exp_f, ftag, 64'(rsp_fault), 64'(exp_f));
         check({rsp_hi, rsp_lo} == exp_v, exp_f ? "R8" : tag,
               64'({rsp_hi, rsp_lo}), 64'(exp_v));
         check(rsp_err == 16'd0, "R8", 64'(rsp_err), 64'd0);
      end
      evt_in = '0; req_valid = 1'b0; cfg_we = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      for (int k = 0; k < 4; k++) mdl[k] = '0;
      mpriv = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check(rsp_valid == 1'b0, "R1", 64'(rsp_valid), 64'd0);

      // R1: counters and monitor bits clear after reset
      for (int k = 0; k < 4; k++) tick(4'd0, 1, 32'(k), 2'd0, 0, 0, 0, 0, 0, 0, 0, "R1");
      for (int k = 0; k < 4; k++) tick(4'd0, 1, 32'(k), 2'd3, 1, 1, 0, 0, 0, 0, 0, "R1");

      // R2: increments per event cycle
      repeat (5) tick(4'b0101);
      tick(4'd0, 1, 32'd0, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R2");
      tick(4'd0, 1, 32'd1, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R2");

      // R6: distinct values per counter
      for (int k = 0; k < 4; k++)
         tick(4'd0, 0, 0, 0, 0, 0, 0, 1, 2'(k), 0, 48'h0A00_0000_0000 + 48'(k * 111), "R10");
      for (int k = 0; k < 4; k++) tick(4'd0, 1, 32'(k), 2'd1, 0, 1, 0, 0, 0, 0, 0, "R6");

      // R7: high/low split
      tick(4'd0, 0, 0, 0, 0, 0, 0, 1, 2'd2, 0, 48'h1234_89AB_CDEF, "R10");
      tick(4'd0, 1, 32'd2, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R7");

      // R11: wrap
      tick(4'd0, 0, 0, 0, 0, 0, 0, 1, 2'd1, 0, 48'hFFFF_FFFF_FFFF, "R10");
      tick(4'b0010);
      tick(4'd0, 1, 32'd1, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R11");

      // R10: load wins over same-cycle event
      tick(4'b1000, 0, 0, 0, 0, 0, 0, 1, 2'd3, 0, 48'd77, "R10");
      tick(4'd0, 1, 32'd3, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R10");

      // R9: snapshot excludes same-edge event, then next read sees it
      tick(4'b0001, 1, 32'd0, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R9");
      tick(4'b0000, 1, 32'd0, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R9");

      // R3: full-width index
      tick(4'd0, 1, 32'd4, 2'd0, 0, 1);
      tick(4'd0, 1, 32'h0001_0002, 2'd0, 0, 1);
      tick(4'd0, 1, 32'hFFFF_FFFF, 2'd0, 1, 1);

      // R4: legacy rule
      tick(4'd0, 1, 32'd1, 2'd3, 0, 0, 0);
      tick(4'd0, 1, 32'd1, 2'd3, 0, 1, 1, 0, 0, 0, 0, "R4");
      tick(4'd0, 1, 32'd1, 2'd0, 0, 0, 1, 0, 0, 0, 0, "R4");

      // R5: native rule with a monitor bit set on counter 2
      tick(4'd0, 0, 0, 0, 0, 0, 0, 1, 2'd2, 1, 48'd1, "R10");
      tick(4'd0, 1, 32'd2, 2'd2, 1, 1, 0);
      tick(4'd0, 1, 32'd2, 2'd0, 1, 0, 1, 0, 0, 0, 0, "R5");
      tick(4'd0, 1, 32'd3, 2'd2, 1, 1, 0, 0, 0, 0, 0, "R5");
      tick(4'd0, 1, 32'd3, 2'd2, 1, 1, 1);
      tick(4'd0, 1, 32'd3, 2'd2, 1, 0, 0);

      // Random mix
      for (int n = 0; n < 600; n++) begin
         logic [31:0] ri;
         int sel;
         sel = int'($urandom % 8);
         ri = (sel < 5) ? 32'($urandom % 4) : (sel == 5) ? 32'($urandom % 8) :
              (sel == 6) ? ({16'($urandom), 16'd1}) : $urandom;
         tick(4'($urandom), bit'($urandom % 2), ri, 2'($urandom), bit'($urandom),
              bit'($urandom), bit'($urandom), ($urandom % 6) == 0, 2'($urandom),
              bit'($urandom), {16'($urandom), 32'($urandom)}, "R2");
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule